// File: doc/BRIEF.md
# Four-Channel Pulse-Width Modulator with Period-Aligned Updates

This block generates one pulse-width modulated output for each of its channels and raises one interrupt line. Software reaches it over a plain 32-bit memory-mapped read/write bus. Each channel has a free-running up-counter, driven through a power-of-two clock divider. Its output level comes from comparing that counter against a duty value. A polarity bit inverts the waveform.

Channels are started and stopped through two write-one-to-act global registers. A stop request is held until the running period finishes, so a stop never cuts a pulse short. A global status register shows which channels are running. While a channel runs, its duty and period registers refuse direct writes. New values go into shadow registers instead, and both are copied in together at the next period boundary. The output therefore never shows a mixed or truncated period.

Every period boundary sets a per-channel event flag. A read of the flag register returns all flags and clears them. The interrupt line is the OR of the flags that software has unmasked.

Top module: `pwm_bank`

## Requirements
- R1: After a synchronous reset every output is low, no channel runs, and every register reads zero.
- R2: Global registers are at these offsets: start register 0x04 (write only), stop register 0x08 (write only), running status 0x0C (read only, bit n = channel n running). Writing a 1 to bit n of the start register starts channel n. Zero bits in a start or stop write leave their channels untouched.
- R3: A stop request takes effect only at the end of the running period. The status bit reads 1 until then and 0 afterwards.
- R4: Channel n occupies 0x200 + n*0x20, with these word offsets: mode 0x00, duty 0x04, duty shadow 0x08, period 0x0C, period shadow 0x10. Duty, period and shadows keep only bits [15:0], and the upper bits read back as zero. The mode register keeps bits [3:0] and bit 9, and its other bits read back as zero.
- R5: While a channel is stopped, writes to its duty and period registers take effect at once. While it runs, those writes are ignored.
- R6: A write to a shadow register is held pending. At the next period end of a running channel, every pending shadow is copied into its live register, so a new duty and a new period begin on the same period.
- R7: The counter runs from 0 to max(period,1)-1. With mode bit 9 clear, the output is low while count < duty and high otherwise. Bit 9 set inverts the output. A stopped channel drives the level of bit 9.
- R8: A duty of 0 gives a constant active level. A duty at or above the period gives a constant inactive level.
- R9: Mode bits [3:0] = p make the counter step once every 2^p clocks. Values above 10 act as 10.
- R10: Each period end of channel n sets bit n of the event register at 0x1C. A read returns the flags and clears them. A period end in the same cycle as the read stays set.
- R11: The interrupt output is high one cycle after any event flag is set while the matching bit of the mask register at 0x10 (read/write, 1 = enabled) is 1.
- R12: Read data appears on the cycle after the read strobe. Unmapped addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | One waveform per channel, registered |
| irq | output | 1 | Interrupt, registered |

## Verification
The bench uses the default parameters: four channels, 16-bit counters and a top divider setting of 10. It can therefore reach the largest divider of 1024 clocks per step, and it confirms that settings above 10 act as 10. Short periods of 1 to 10 counts make the waveform tests cheap enough to count high cycles over whole periods for both polarities and for both duty extremes. A period of 1000 counts leaves a wide window to check that direct writes are refused while a channel runs, that shadows wait for the boundary, and that a stop request waits for the running period to end.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  // global register offsets
  localparam int unsigned START_OFS = 'h04;
  localparam int unsigned STOP_OFS  = 'h08;
  localparam int unsigned RUN_OFS   = 'h0C;
  localparam int unsigned MASK_OFS  = 'h10;
  localparam int unsigned EVT_OFS   = 'h1C;

  // channel windows
  localparam int unsigned CH_BASE   = 'h200;
  localparam int unsigned CH_STRIDE = 'h20;

  // word index inside a channel window
  typedef enum logic [2:0] {
    W_MODE  = 3'd0,
    W_DUTY  = 3'd1,
    W_DSHAD = 3'd2,
    W_PER   = 3'd3,
    W_PSHAD = 3'd4
  } ch_word_e;

  localparam int unsigned INV_BIT = 9;

endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int PSEL_MAX = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic [3:0] psel,
  output logic       tick
);
  localparam int PW = PSEL_MAX + 1;

  logic [3:0]    eff;
  logic [PW-1:0] lim;
  logic [PW-1:0] div_q;

  always_comb begin
    eff = (psel > 4'(PSEL_MAX)) ? 4'(PSEL_MAX) : psel;
    lim = (PW'(1) << eff) - PW'(1);
  end

  // >= keeps the divider safe when the setting shrinks mid-count
  assign tick = !clr && (div_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (tick)   div_q <= '0;
    else             div_q <= div_q + PW'(1);
  end

  // R9
  tick_restart_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (div_q == '0));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int CW       = 16,
  parameter int DW       = 32,
  parameter int PSEL_MAX = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    word,
  input  logic [CW-1:0] wdata,
  input  logic          start,
  input  logic          stop,
  output logic          running,
  output logic          period_end,
  output logic          pwm_o,
  output logic [DW-1:0] rdata
);

  logic [3:0]    psel_q;
  logic          inv_q;
  logic [CW-1:0] duty_q, per_q, dshad_q, pshad_q, cnt_q;
  logic          dpend_q, ppend_q, run_q, stop_pend_q;
  logic          tick, wrap;
  logic [CW-1:0] last_cnt;

  pwm_tick_gen #(.PSEL_MAX(PSEL_MAX)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (!run_q),
    .psel (psel_q),
    .tick (tick)
  );

  assign last_cnt   = (per_q == '0) ? '0 : per_q - CW'(1);
  assign wrap       = run_q && tick && (cnt_q >= last_cnt);
  assign period_end = wrap;
  assign running    = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      psel_q      <= '0;
      inv_q       <= 1'b0;
      duty_q      <= '0;
      per_q       <= '0;
      dshad_q     <= '0;
      pshad_q     <= '0;
      dpend_q     <= 1'b0;
      ppend_q     <= 1'b0;
      cnt_q       <= '0;
      run_q       <= 1'b0;
      stop_pend_q <= 1'b0;
      pwm_o       <= 1'b0;
    end else begin
      // counter
      if (!run_q)     cnt_q <= '0;
      else if (wrap)  cnt_q <= '0;
      else if (tick)  cnt_q <= cnt_q + CW'(1);

      // period-boundary transfer of shadows
      if (wrap) begin
        if (dpend_q) begin
          duty_q  <= dshad_q;
          dpend_q <= 1'b0;
        end
        if (ppend_q) begin
          per_q   <= pshad_q;
          ppend_q <= 1'b0;
        end
      end

      // register writes
      if (wr_en) begin
        unique case (word)
          W_MODE: begin
            psel_q <= wdata[3:0];
            inv_q  <= wdata[INV_BIT];
          end
          W_DUTY:  if (!run_q) duty_q <= wdata;
          W_DSHAD: begin
            dshad_q <= wdata;
            dpend_q <= 1'b1;
          end
          W_PER:   if (!run_q) per_q <= wdata;
          W_PSHAD: begin
            pshad_q <= wdata;
            ppend_q <= 1'b1;
          end
          default: ;
        endcase
      end

      // run control: stop waits for the boundary, start wins ties
      if (stop && run_q) stop_pend_q <= 1'b1;
      if (wrap && stop_pend_q) begin
        run_q       <= 1'b0;
        stop_pend_q <= 1'b0;
      end
      if (start) begin
        run_q       <= 1'b1;
        stop_pend_q <= 1'b0;
      end

      pwm_o <= (run_q && (cnt_q >= duty_q)) ^ inv_q;
    end
  end

  always_comb begin
    unique case (word)
      W_MODE:  rdata = DW'({inv_q, 5'b0, psel_q});
      W_DUTY:  rdata = DW'(duty_q);
      W_DSHAD: rdata = DW'(dshad_q);
      W_PER:   rdata = DW'(per_q);
      W_PSHAD: rdata = DW'(pshad_q);
      default: rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata[CW-1:INV_BIT+1], wdata[INV_BIT-1:4]};

  // R2
  start_takes_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> run_q);

  // R3
  stop_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(run_q) |-> $past(wrap));

  // R5
  live_regs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !wrap) |=> ($stable(duty_q) && $stable(per_q)));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q <= last_cnt));

  // R7
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> (pwm_o == $past(inv_q)));

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 12,
  parameter int DW       = 32,
  parameter int CW       = 16,
  parameter int PSEL_MAX = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);

  localparam int CH_IW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [AW-1:0] A_START = AW'(START_OFS);
  localparam logic [AW-1:0] A_STOP  = AW'(STOP_OFS);
  localparam logic [AW-1:0] A_RUN   = AW'(RUN_OFS);
  localparam logic [AW-1:0] A_MASK  = AW'(MASK_OFS);
  localparam logic [AW-1:0] A_EVT   = AW'(EVT_OFS);
  localparam logic [AW-1:0] A_CH0   = AW'(CH_BASE);
  localparam logic [AW-1:0] A_CHEND = AW'(CH_BASE + NCH * CH_STRIDE);

  logic [NCH-1:0] start_v, stop_v, run_v, pend_v, ch_wr;
  logic [NCH-1:0] evt_q, mask_q;
  logic [DW-1:0]  ch_rd [NCH];
  logic [DW-1:0]  rd_mux;
  logic [AW-1:0]  ch_off;
  logic [CH_IW-1:0] ch_idx;
  logic           in_ch, evt_rd;

  assign in_ch  = (bus_addr >= A_CH0) && (bus_addr < A_CHEND);
  assign ch_off = bus_addr - A_CH0;
  assign ch_idx = ch_off[CH_IW+4:5];
  assign evt_rd = bus_rd && (bus_addr == A_EVT);

  assign start_v = (bus_wr && bus_addr == A_START) ? bus_wdata[NCH-1:0] : '0;
  assign stop_v  = (bus_wr && bus_addr == A_STOP)  ? bus_wdata[NCH-1:0] : '0;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign ch_wr[i] = bus_wr && in_ch && (ch_idx == CH_IW'(i));
    pwm_chan #(.CW(CW), .DW(DW), .PSEL_MAX(PSEL_MAX)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (ch_wr[i]),
      .word       (bus_addr[4:2]),
      .wdata      (bus_wdata[CW-1:0]),
      .start      (start_v[i]),
      .stop       (stop_v[i]),
      .running    (run_v[i]),
      .period_end (pend_v[i]),
      .pwm_o      (pwm_out[i]),
      .rdata      (ch_rd[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (in_ch)                      rd_mux = ch_rd[ch_idx];
    else if (bus_addr == A_RUN)     rd_mux = DW'(run_v);
    else if (bus_addr == A_MASK)    rd_mux = DW'(mask_q);
    else if (bus_addr == A_EVT)     rd_mux = DW'(evt_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_q     <= '0;
      mask_q    <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      evt_q     <= (evt_rd ? '0 : evt_q) | pend_v;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[NCH-1:0];
      irq       <= |(evt_q & mask_q);
      bus_rdata <= bus_rd ? rd_mux : '0;
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_wdata[DW-1:CW], ch_off[AW-1:CH_IW+5],
                         ch_off[4:0], bus_addr[1:0]};

  // R10
  evt_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_rd && !(|pend_v)) |=> (evt_q == '0));

  // R10
  evt_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend_v) |=> ((evt_q & $past(pend_v)) == $past(pend_v)));

  // R11
  irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq);

  // R12
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_bank u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  ch;
    logic [3:0]  ps;
    logic        inv;
    logic [15:0] prd;
    logic [15:0] dty;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    {2'd0, 4'd0,  1'b0, 16'd10, 16'd3},
    {2'd1, 4'd0,  1'b1, 16'd10, 16'd3},
    {2'd2, 4'd0,  1'b0, 16'd8,  16'd0},
    {2'd3, 4'd0,  1'b0, 16'd8,  16'd8},
    {2'd0, 4'd0,  1'b1, 16'd8,  16'd20},
    {2'd1, 4'd2,  1'b0, 16'd4,  16'd1},
    {2'd2, 4'd15, 1'b0, 16'd2,  16'd1},
    {2'd3, 4'd0,  1'b0, 16'd1,  16'd0}
  };

  function automatic logic [11:0] cha(input int n, input int w);
    return 12'(32'h200 + n * 32 + w * 4);
  endfunction

  function automatic int eff_ps(input vec_t v);
    return (v.ps > 10) ? 10 : int'(v.ps);
  endfunction

  function automatic int eff_prd(input vec_t v);
    return (v.prd == 0) ? 1 : int'(v.prd);
  endfunction

  function automatic int exp_highs(input vec_t v);
    int p = eff_prd(v);
    int d = (int'(v.dty) > p) ? p : int'(v.dty);
    int per = v.inv ? d : p - d;
    return 3 * per * (1 << eff_ps(v));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    vec_t v;
    int highs, win;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pwm_out", 32'(pwm_out), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    rd(12'h00C, d); check("R1 status", d, 32'h0);
    rd(12'h01C, d); check("R1 events", d, 32'h0);
    rd(cha(0, 1), d); check("R1 duty", d, 32'h0);

    // R4 field widths and placement
    wr(cha(1, 1), 32'hABCD_1234);
    rd(cha(1, 1), d); check("R4 duty low bits", d, 32'h0000_1234);
    wr(cha(1, 0), 32'hFFFF_FFFF);
    rd(cha(1, 0), d); check("R4 mode bits", d, 32'h0000_020F);
    wr(cha(1, 0), 32'h0);

    // R12 unmapped address
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, d); check("R12 unmapped read", d, 32'h0);

    // R2 zero bits do nothing, ones start
    wr(12'h004, 32'h0);
    rd(12'h00C, d); check("R2 zero start", d, 32'h0);
    wr(12'h004, 32'h5);
    rd(12'h00C, d); check("R2 start ch0 ch2", d, 32'h5);
    wr(12'h008, 32'h5);
    idle(6);
    rd(12'h00C, d); check("R2 stop ch0 ch2", d, 32'h0);
    rd(12'h01C, d);

    // R7 R8 R9 waveform table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wr(cha(v.ch, 0), {22'd0, v.inv, 5'd0, v.ps});
      wr(cha(v.ch, 3), 32'(v.prd));
      wr(cha(v.ch, 1), 32'(v.dty));
      wr(12'h004, 32'(1) << v.ch);
      idle(4);
      win = 3 * eff_prd(v) * (1 << eff_ps(v));
      highs = 0;
      for (int k = 0; k < win; k++) begin
        @(negedge clk);
        if (pwm_out[v.ch]) highs++;
      end
      check($sformatf("R7 R8 R9 vector %0d high count", i), 32'(highs), 32'(exp_highs(v)));
      wr(12'h008, 32'(1) << v.ch);
      idle(eff_prd(v) * (1 << eff_ps(v)) + 10);
      rd(12'h00C, d);
      check($sformatf("R3 vector %0d stopped", i), d & (32'(1) << v.ch), 32'h0);
      check($sformatf("R7 vector %0d idle level", i), 32'(pwm_out[v.ch]), 32'(v.inv));
    end
    rd(12'h01C, d);

    // R5 R6 R10 shadow registers on a long period
    wr(cha(0, 0), 32'h0);
    wr(cha(0, 3), 32'd1000);
    wr(cha(0, 1), 32'd1000);
    rd(12'h01C, d);
    wr(12'h004, 32'h1);
    idle(5);
    wr(cha(0, 1), 32'd5);
    rd(cha(0, 1), d); check("R5 duty write ignored while running", d, 32'd1000);
    check("R5 output still inactive", 32'(pwm_out[0]), 32'h0);
    wr(cha(0, 3), 32'd7);
    rd(cha(0, 3), d); check("R5 period write ignored while running", d, 32'd1000);
    wr(cha(0, 2), 32'd500);
    wr(cha(0, 4), 32'd600);
    rd(cha(0, 1), d); check("R6 duty waits for boundary", d, 32'd1000);
    rd(cha(0, 3), d); check("R6 period waits for boundary", d, 32'd1000);
    rd(cha(0, 2), d); check("R6 duty shadow readback", d, 32'd500);
    rd(12'h01C, d); check("R10 no event before period end", d, 32'h0);
    idle(1010);
    rd(cha(0, 1), d); check("R6 duty applied", d, 32'd500);
    rd(cha(0, 3), d); check("R6 period applied", d, 32'd600);
    rd(12'h01C, d); check("R10 event set", d, 32'h1);
    rd(12'h01C, d); check("R10 event cleared by read", d, 32'h0);
    highs = 0;
    for (int k = 0; k < 1200; k++) begin
      @(negedge clk);
      if (pwm_out[0]) highs++;
    end
    check("R6 new duty and period together", 32'(highs), 32'd200);

    // R11 interrupt mask
    wr(12'h010, 32'h1);
    rd(12'h010, d); check("R11 mask readback", d, 32'h1);
    idle(650);
    check("R11 irq raised", 32'(irq), 32'h1);
    rd(12'h01C, d);
    @(negedge clk);
    check("R11 irq dropped after event read", 32'(irq), 32'h0);
    wr(12'h010, 32'h0);
    idle(650);
    check("R11 irq masked", 32'(irq), 32'h0);
    rd(12'h01C, d); check("R10 masked event still flagged", d, 32'h1);

    // R3 deferred stop, aligned just after a boundary
    wr(12'h010, 32'h1);
    for (int k = 0; k < 800 && !irq; k++) @(negedge clk);
    wr(12'h008, 32'h1);
    rd(12'h00C, d); check("R3 still running after stop request", d, 32'h1);
    idle(620);
    rd(12'h00C, d); check("R3 stopped after period end", d, 32'h0);
    check("R3 output inactive after stop", 32'(pwm_out[0]), 32'h0);

    finish_run();
  end

endmodule